// File: doc/BRIEF.md
# Goldschmidt Iterative Divider

The block divides an unsigned fractional numerator by an unsigned fractional denominator. It multiplies both operands by the same correction factor again and again. The denominator moves toward one, so the numerator moves toward the quotient. The error left in the denominator is squared on every round, so the number of correct bits roughly doubles each round, rather than growing by one bit per step.

When a request is accepted, the denominator is normalised by a left shift into the range [0.5, 1), using the position of its leading one. The numerator is held unshifted. In each round the factor r = 2 − y is formed as the two's complement of the denominator register. A single shared multiplier then updates the numerator in one cycle and the denominator in the next. After the last round, the numerator register is shifted left by the normalisation amount and rounded down to the output format.

Both operands are FRAC_W-bit pure fractions, value = code / 2^FRAC_W. The quotient has FRAC_W integer bits above FRAC_W fraction bits. ITERS sets the number of rounds. The defaults are FRAC_W = 16 and ITERS = 5, which gives a 32-bit result.

Top module: `gsd_divider`

## Requirements
- R1: While reset is held and after it is released, done is 0 and quotient is 0.
- R2: For a nonzero denominator b and numerator a, the quotient is within 4 codes of floor(a·2^FRAC_W / b). Quotient bits [2·FRAC_W−1:FRAC_W] are the integer part and bits [FRAC_W−1:0] are the fraction.
- R3: A start that is accepted at a clock edge makes done high for exactly one cycle, in the cycle that follows the edge 2·ITERS+1 edges later (11 with the defaults). done is low in every other cycle.
- R4: A start raised while a division is in progress is ignored. It produces no extra done pulse, and the result still belongs to the operands that were accepted first.
- R5: The quotient changes only in a cycle in which done is high, and it holds its value until the next done.
- R6: A zero denominator gives a quotient of all ones, with the same latency as any other request.
- R7: A zero numerator with a nonzero denominator gives a quotient of exactly 0.
- R8: R2 holds at the limits of the normalisation shift: a denominator with its top bit set (no shift), a denominator of 1 (the largest shift) and an exact power of two.
- R9: A start raised in the cycle in which done is high is accepted at the next edge, so requests can follow each other with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a division when the block is idle |
| numer | input | FRAC_W | Numerator, unsigned fraction |
| denom | input | FRAC_W | Denominator, unsigned fraction |
| quotient | output | 2·FRAC_W | Result: FRAC_W integer bits above FRAC_W fraction bits |
| done | output | 1 | One-cycle pulse when quotient is updated |

## Verification
The timing window hardest to reach from the ports is a new start raised in the same cycle as done. There the controller has only just returned to idle, and a single-cycle slip would either lose the request or merge it with the previous one. The stimulus waits on the reference model's predicted done cycle and raises start at exactly that moment. It also raises start a few cycles into a running division, to show that the request is dropped. Accuracy is probed hardest at a denominator of 1, where the largest shift magnifies any rounding left in the numerator register. That case is driven directly, together with pseudo-random denominators shifted right by every amount from 0 to FRAC_W−1.

// File: rtl/gsd_pkg.sv
package gsd_pkg;
  // Strobes from the sequencer to the datapath, one per activity.
  typedef struct packed {
    logic load;    // capture and normalise the operands
    logic mulX;    // numerator times factor
    logic mulY;    // denominator times factor
    logic finish;  // denormalise and publish the quotient
  } gsdStrobes_t;
endpackage

// File: rtl/gsd_scaler.sv
module gsd_scaler #(
  parameter int FRAC_W = 16,
  localparam int SW = $clog2(FRAC_W)
) (
  input  logic [FRAC_W-1:0] denom,
  output logic [FRAC_W-1:0] normDenom,
  output logic [SW-1:0]     lzCount,
  output logic              isZero
);
  // Leading-zero count: the highest set bit wins, so scan upward.
  always_comb begin
    lzCount = '0;
    for (int i = 0; i < FRAC_W; i++) begin
      if (denom[i]) lzCount = SW'(FRAC_W - 1 - i);
    end
  end

  assign normDenom = denom << lzCount;
  assign isZero    = (denom == '0);
endmodule

// File: rtl/gsd_ctrl.sv
module gsd_ctrl import gsd_pkg::*; #(
  parameter int ITERS = 5,
  localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output gsdStrobes_t strb
);
  typedef enum logic [1:0] { ST_IDLE, ST_MULX, ST_MULY, ST_FIN } state_t;

  state_t        state;
  logic [CW-1:0] iterCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_MULX;
          iterCnt <= '0;
        end
        ST_MULX: state <= ST_MULY;
        ST_MULY: begin
          if (iterCnt == CW'(ITERS - 1)) begin
            state <= ST_FIN;
          end else begin
            state   <= ST_MULX;
            iterCnt <= iterCnt + CW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load   = (state == ST_IDLE) && start;
    strb.mulX   = (state == ST_MULX);
    strb.mulY   = (state == ST_MULY);
    strb.finish = (state == ST_FIN);
  end
endmodule

// File: rtl/gsd_datapath.sv
module gsd_datapath import gsd_pkg::*; #(
  parameter int FRAC_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  gsdStrobes_t           strb,
  input  logic [FRAC_W-1:0]     numer,
  input  logic [FRAC_W-1:0]     denom,
  output logic [2*FRAC_W-1:0]   quotient,
  output logic                  done
);
  localparam int FI    = 2 * FRAC_W + 2;  // internal fraction bits
  localparam int XW    = FI + 1;          // one integer bit
  localparam int QW    = 2 * FRAC_W;
  localparam int GUARD = FI - FRAC_W;     // bits dropped at the output
  localparam int SW    = $clog2(FRAC_W);

  logic [FRAC_W-1:0] normDenom;
  logic [SW-1:0]     lzCount;
  logic              isZero;

  gsd_scaler #(.FRAC_W(FRAC_W)) i_scaler (
    .denom    (denom),
    .normDenom(normDenom),
    .lzCount  (lzCount),
    .isZero   (isZero)
  );

  logic [XW-1:0] xReg, yReg;
  logic [SW-1:0] shiftReg;
  logic          zeroReg;

  // r = 2 - y : two's complement of y; for y in [0.5,1) the integer bit ends up set.
  logic [XW-1:0]   rFactor;
  logic [XW-1:0]   opA;
  logic [2*XW-1:0] prodFull;
  logic [XW-1:0]   prodKeep;
  logic [FI-1:0]   unusedProdLow;
  logic            unusedProdTop;

  assign rFactor  = ~yReg + XW'(1);
  assign opA      = strb.mulY ? yReg : xReg;
  assign prodFull = {{XW{1'b0}}, opA} * {{XW{1'b0}}, rFactor};
  assign prodKeep = prodFull[FI +: XW];
  assign unusedProdLow = prodFull[FI-1:0];
  assign unusedProdTop = prodFull[2*XW-1];

  // Denormalise: shift left by the normalisation amount, drop the guard bits.
  logic [XW-1:0] quotWide;
  logic [XW-QW-1:0] unusedQuotTop;
  assign quotWide      = xReg >> (GUARD - int'(shiftReg));
  assign unusedQuotTop = quotWide[XW-1:QW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xReg     <= '0;
      yReg     <= '0;
      shiftReg <= '0;
      zeroReg  <= 1'b0;
      quotient <= '0;
      done     <= 1'b0;
    end else begin
      done <= strb.finish;
      if (strb.load) begin
        xReg     <= {1'b0, numer, {GUARD{1'b0}}};
        yReg     <= {1'b0, normDenom, {GUARD{1'b0}}};
        shiftReg <= lzCount;
        zeroReg  <= isZero;
      end
      if (strb.mulX) xReg <= prodKeep;
      if (strb.mulY) yReg <= prodKeep;
      if (strb.finish) begin
        quotient <= zeroReg ? {QW{1'b1}} : quotWide[QW-1:0];
      end
    end
  end
endmodule

// File: rtl/gsd_divider.sv
module gsd_divider import gsd_pkg::*; #(
  parameter int FRAC_W = 16,
  parameter int ITERS  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [FRAC_W-1:0]   numer,
  input  logic [FRAC_W-1:0]   denom,
  output logic [2*FRAC_W-1:0] quotient,
  output logic                done
);
  gsdStrobes_t strb;

  gsd_ctrl #(.ITERS(ITERS)) i_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .strb (strb)
  );

  gsd_datapath #(.FRAC_W(FRAC_W)) i_datapath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .numer   (numer),
    .denom   (denom),
    .quotient(quotient),
    .done    (done)
  );
endmodule

// File: rtl/gsd_checker.sv
module gsd_checker import gsd_pkg::*; #(
  parameter int FRAC_W = 16,
  parameter int ITERS  = 5,
  localparam int LAT = 2 * ITERS + 1,
  localparam int LW  = $clog2(LAT + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [FRAC_W-1:0]   numer,
  input logic [FRAC_W-1:0]   denom,
  input logic [2*FRAC_W-1:0] quotient,
  input logic                done,
  input gsdStrobes_t         strb
);
  logic          run;
  logic [LW-1:0] cnt;
  logic          zDen, zNum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      cnt  <= '0;
      zDen <= 1'b0;
      zNum <= 1'b0;
    end else if (strb.load) begin
      run  <= 1'b1;
      cnt  <= '0;
      zDen <= (denom == '0);
      zNum <= (numer == '0);
    end else if (run) begin
      cnt <= cnt + LW'(1);
      if (cnt == LW'(LAT - 1)) run <= 1'b0;
    end
  end

  // R3: done only at the due cycle, and for one cycle
  p_done_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!run && cnt == LW'(LAT)));
  p_done_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == LW'(LAT - 1)) |=> done);
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4: no acceptance during a run
  p_no_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |-> !run);
  // R9: start while idle (including the done cycle) is taken
  p_accept_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !run) |-> strb.load);
  // R5: quotient moves only with done
  p_quot_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(quotient) |-> done);
  // R6: divide by zero saturates
  p_zero_den_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zDen) |-> (quotient == '1));
  // R7: zero numerator gives zero
  p_zero_num_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zNum && !zDen) |-> (quotient == '0));
endmodule

bind gsd_divider gsd_checker #(.FRAC_W(FRAC_W), .ITERS(ITERS)) i_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .numer   (numer),
  .denom   (denom),
  .quotient(quotient),
  .done    (done),
  .strb    (strb)
);

// File: tb/test_gsd_divider.sv
module test_gsd_divider;
  localparam int FRAC_W = 16;
  localparam int ITERS  = 5;
  localparam int LAT    = 2 * ITERS + 1;
  localparam int QW     = 2 * FRAC_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [FRAC_W-1:0] numer = '0;
  logic [FRAC_W-1:0] denom = '0;
  logic [QW-1:0]     quotient;
  logic              done;

  gsd_divider #(.FRAC_W(FRAC_W), .ITERS(ITERS)) i_gsd_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .numer(numer),
    .denom(denom), .quotient(quotient), .done(done)
  );

  always #2 clk = ~clk;  // 250 MHz

  int    nChecks = 0;
  int    nErrors = 0;
  string curTag  = "R2";

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: busy flag, edge counter, captured operands.
  bit             mBusy = 0;
  int             mCnt = 0;
  bit             expDone = 0;
  longint         mA = 0, mB = 0;
  logic [QW-1:0]  lastQ = '0;
  bit             checking = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mBusy = 0; mCnt = 0; expDone = 0;
    end else begin
      expDone = 0;
      if (mBusy) begin
        mCnt++;
        if (mCnt == LAT) begin
          mBusy   = 0;
          expDone = 1;
        end
      end else if (start) begin
        mBusy = 1; mCnt = 0;
        mA = longint'(numer); mB = longint'(denom);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && checking) begin
      chk(done == expDone, "R3", longint'(done), longint'(expDone));
      if (expDone) begin
        if (mB == 0) begin
          chk(quotient == '1, "R6", longint'(quotient), 64'hFFFF_FFFF);
        end else if (mA == 0) begin
          chk(quotient == '0, "R7", longint'(quotient), 0);
        end else begin
          longint refQ, diff;
          refQ = (mA <<< FRAC_W) / mB;
          diff = longint'(quotient) - refQ;
          chk(diff <= 4 && diff >= -4, curTag, longint'(quotient), refQ);
        end
        lastQ = quotient;
      end else begin
        chk(quotient == lastQ, "R5", longint'(quotient), longint'(lastQ));
      end
    end
  end

  task automatic issue(input logic [FRAC_W-1:0] a, input logic [FRAC_W-1:0] b);
    @(negedge clk);
    start = 1'b1; numer = a; denom = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (mBusy || expDone) @(negedge clk);
  endtask

  task automatic divide(input logic [FRAC_W-1:0] a, input logic [FRAC_W-1:0] b, input string tag);
    curTag = tag;
    issue(a, b);
    waitIdle();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1", longint'(done), 0);
    chk(quotient == '0, "R1", longint'(quotient), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && quotient == '0, "R1", longint'(quotient), 0);
    checking = 1;

    divide(16'h4000, 16'h8000, "R8");   // 0.5 exactly, power of two
    divide(16'hFFFF, 16'h0001, "R8");   // largest shift
    divide(16'h1234, 16'hF000, "R8");   // top bit set, no shift
    divide(16'hFFFF, 16'hFFFF, "R2");
    divide(16'h0001, 16'hFFFF, "R2");
    divide(16'h8000, 16'h0003, "R2");
    divide(16'h0000, 16'h1234, "R7");
    divide(16'h1234, 16'h0000, "R6");

    // R4: second start while running is dropped
    curTag = "R4";
    issue(16'h3000, 16'h0700);
    repeat (3) @(negedge clk);
    issue(16'hFFFF, 16'h0001);
    waitIdle();

    // R9: start raised in the done cycle
    curTag = "R9";
    issue(16'h2222, 16'h0555);
    @(negedge clk);
    while (!expDone) @(negedge clk);
    start = 1'b1; numer = 16'h7777; denom = 16'h0123;
    @(negedge clk);
    start = 1'b0;
    waitIdle();

    for (int i = 0; i < 64; i++) begin
      logic [FRAC_W-1:0] a, b;
      a = FRAC_W'($urandom);
      b = FRAC_W'($urandom) >> (i % FRAC_W);
      if (b == '0) b = 16'h0001;
      divide(a, b, (i % FRAC_W == 0 || i % FRAC_W == FRAC_W - 1) ? "R8" : "R2");
    end

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule